// File: doc/BRIEF.md
# Symbol-to-Byte Error Corrector

This block takes the output of a Reed-Solomon locator for one page and applies each correction to the page held in a byte-wide RAM. The page is a 2048-byte data region followed by a small spare region. The codeword is made of 12-bit symbols packed most-significant-bit first. Symbol 0 holds only 8 bits and covers data byte 0. Every later symbol p starts at bit 12p-4 of the byte stream. A symbol therefore lands on two bytes, and one symbol spans the last data byte and the first spare byte.

A page opens with a `start` pulse that carries the number of errors. The (position, pattern) pairs then arrive on a valid/ready stream. The source may hold `in_valid` high for any number of cycles. A pair transfers only in a cycle where `in_valid` and `in_ready` are both high. `in_pos` and `in_pat` must stay stable while `in_valid` waits. The block raises `in_ready` only when it can take the next pair of an open page.

Each byte update is a read, an XOR and a write-back on one RAM port. The RAM returns read data one cycle after the read. At the end of the page, a one-cycle `done` pulse reports how many symbols were corrected, or that the page cannot be corrected.

Top module: `sym2byte_corrector`

## Requirements
- R1: After reset, `done`, `fail`, `fixed_cnt`, `in_ready`, `mem_rd` and `mem_we` are all 0.
- R2: For an odd position p with 1 <= p < 1365, data byte floor(3p/2) is XORed with pat[11:4] and data byte floor(3p/2)+1 is XORed with {pat[3:0],4'b0000}.
- R3: For an even position p with 2 <= p < 1365, data byte 3p/2-1 is XORed with {4'b0000,pat[11:8]} and data byte 3p/2 is XORed with pat[7:0].
- R4: Position 0 with a pattern of at most 0xFF XORs data byte 0 with pat[7:0] and touches no other byte. Position 0 with a pattern above 0xFF fails the page.
- R5: Position 1365 XORs data byte 2047 with pat[11:4] and spare byte 0 with {pat[3:0],4'b0000}.
- R6: Positions 1366 to 1374 use the formulas of R2 and R3 (odd and even) with 2048 subtracted from the byte index, and they address the spare region (`mem_spare`=1).
- R7: A position above 1374 fails the page. Bytes updated earlier in the page keep their new values. The remaining pairs of the page are still accepted but are not applied.
- R8: A `start` count of 0 ends the page with `done`, `fixed_cnt`=0 and `fail`=0. A count above 4 ends it with `fail`=1, and `in_ready` never rises for that page.
- R9: Several corrections that touch the same byte within one page compose: the byte ends up XORed with all of their masks.
- R10: `done` is high for exactly one cycle. With it, `fail` shows whether the page failed, and `fixed_cnt` shows the number of pairs applied (0 when `fail`=1). Both hold until the next `done`.
- R11: `in_ready` is high only while an open page still waits for a pair, and at most one pair transfers per handshake. `done` comes 2 cycles after `start` for counts of 0 or above 4. Otherwise `done` comes after the last handshake of the page: 6 cycles after it for a two-byte correction, 4 cycles for position 0, and 2 cycles for a pair that fails or is drained.
- R12: Each byte update drives `mem_rd` in one cycle and, in the next cycle, `mem_we` to the same region and address, with `mem_wdata` = `mem_rdata` XOR mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a page; ignored while a page is open |
| err_cnt | input | 3 | Number of pairs in the page, sampled with `start` |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | The block takes the offered pair this cycle |
| in_pos | input | 12 | Symbol position |
| in_pat | input | 12 | Symbol error pattern |
| mem_rd | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_spare | output | 1 | 1 selects the spare region, 0 the data region |
| mem_addr | output | 11 | Byte address within the selected region |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| done | output | 1 | One-cycle end-of-page pulse |
| fixed_cnt | output | 3 | Number of symbols corrected |
| fail | output | 1 | The page could not be corrected |

## Verification
`done` is due 2 cycles after a `start` that carries no pairs or too many. For other pages it is due 6, 4 or 2 cycles after the last handshake: 6 for a two-byte correction, 4 for position 0, and 2 for a failing or drained pair. `in_ready` must be low in the cycle right after a pair that is applied. The bench drives and samples on falling edges and keeps a cycle counter. It notes the cycle of every handshake and compares the cycle in which `done` appears with the due cycle. It checks the RAM contents only after `done`, against a model that flips the pattern bits one at a time at stream bit offset 12p-4.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Width of one code symbol; the nibble split in the mapper assumes 12.
  localparam int SYM_W     = 12;
  // Address field carried inside a byte operation, wide enough for any region.
  localparam int OP_ADDR_W = 16;

  typedef struct packed {
    logic                 en;
    logic                 spare;
    logic [OP_ADDR_W-1:0] addr;
    logic [7:0]           mask;
  } byte_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_TAKE,
    ST_RD0,
    ST_WR0,
    ST_RD1,
    ST_WR1
  } seq_state_t;

endpackage

// File: rtl/corr_sym_map.sv
module corr_sym_map
  import corr_pkg::*;
#(
  parameter int DATA_BYTES = 2048,
  parameter int LAST_POS   = 1374
) (
  input  logic [SYM_W-1:0] pos,
  input  logic [SYM_W-1:0] pat,
  output byte_op_t         op0,
  output byte_op_t         op1,
  output logic             bad
);

  localparam int LIN_W = SYM_W + 3;

  logic             pos_zero;
  logic [LIN_W-1:0] tri_pos;
  logic [LIN_W-1:0] half;
  logic [LIN_W-1:0] idx [2];
  logic [7:0]       msk [2];

  // Linear byte index and mask for each of the two bytes a symbol covers.
  always_comb begin
    pos_zero = (pos == '0);
    tri_pos  = (LIN_W'(pos) << 1) + LIN_W'(pos);
    half     = tri_pos >> 1;
    if (pos[0]) begin
      idx[0] = half;
      msk[0] = pat[11:4];
      idx[1] = half + LIN_W'(1);
      msk[1] = {pat[3:0], 4'h0};
    end else if (pos_zero) begin
      idx[0] = '0;
      msk[0] = pat[7:0];
      idx[1] = '0;
      msk[1] = '0;
    end else begin
      idx[0] = half - LIN_W'(1);
      msk[0] = {4'h0, pat[11:8]};
      idx[1] = half;
      msk[1] = pat[7:0];
    end
  end

  // Rebase every byte index past the data region onto the spare region.
  for (genvar g = 0; g < 2; g++) begin : g_place
    byte_op_t plc;
    always_comb begin
      plc.en   = 1'b1;
      plc.mask = msk[g];
      if (idx[g] >= LIN_W'(DATA_BYTES)) begin
        plc.spare = 1'b1;
        plc.addr  = OP_ADDR_W'(idx[g] - LIN_W'(DATA_BYTES));
      end else begin
        plc.spare = 1'b0;
        plc.addr  = OP_ADDR_W'(idx[g]);
      end
    end
  end

  always_comb begin
    op0    = g_place[0].plc;
    op1    = g_place[1].plc;
    op1.en = !pos_zero;
    bad    = (int'(pos) > LAST_POS) || (pos_zero && (pat[11:8] != 4'h0));
  end

endmodule

// File: rtl/corr_rmw_seq.sv
module corr_rmw_seq
  import corr_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SPARE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  byte_op_t          map_op0,
  input  byte_op_t          map_op1,
  input  logic              map_bad,
  input  logic              remain_zero,
  input  logic              page_failed,
  output logic              open_pg,
  output logic              take,
  output logic              close_pg,
  output logic              mem_rd,
  output logic              mem_we,
  output logic              mem_spare,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  seq_state_t st_q, st_d;
  byte_op_t   op0_q, op1_q, cur;
  logic       second;

  always_comb begin
    in_ready = (st_q == ST_TAKE);
    take     = in_ready && in_valid;
    open_pg  = (st_q == ST_IDLE) && start;
    close_pg = (st_q == ST_NEXT) && remain_zero;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_NEXT;
      ST_NEXT: st_d = remain_zero ? ST_IDLE : ST_TAKE;
      ST_TAKE: if (in_valid) st_d = (map_bad || page_failed) ? ST_NEXT : ST_RD0;
      ST_RD0:  st_d = ST_WR0;
      ST_WR0:  st_d = op1_q.en ? ST_RD1 : ST_NEXT;
      ST_RD1:  st_d = ST_WR1;
      ST_WR1:  st_d = ST_NEXT;
      default: st_d = ST_IDLE;
    endcase

    second    = (st_q == ST_RD1) || (st_q == ST_WR1);
    cur       = second ? op1_q : op0_q;
    mem_rd    = (st_q == ST_RD0) || (st_q == ST_RD1);
    mem_we    = (st_q == ST_WR0) || (st_q == ST_WR1);
    mem_spare = (mem_rd || mem_we) && cur.spare;
    mem_addr  = (mem_rd || mem_we) ? cur.addr[ADDR_W-1:0] : '0;
    mem_wdata = mem_rdata ^ cur.mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op0_q <= '0;
      op1_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        op0_q <= map_op0;
        op1_q <= map_op1;
      end
    end
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_rd && !mem_we)); // R11
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_rd)); // R12
  AST_WRITE_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr == $past(mem_addr)) && (mem_spare == $past(mem_spare)))); // R12
  AST_SPARE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_spare) |-> (int'(mem_addr) < SPARE_BYTES)); // R6

endmodule

// File: rtl/corr_tally.sv
module corr_tally #(
  parameter int MAX_ERR = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_pg,
  input  logic [CNT_W-1:0] open_cnt,
  input  logic             take,
  input  logic             take_bad,
  input  logic             close_pg,
  output logic             remain_zero,
  output logic             page_failed,
  output logic             done,
  output logic [CNT_W-1:0] fixed_cnt,
  output logic             fail
);

  logic [CNT_W-1:0] remain_q, applied_q, res_cnt_q;
  logic             failed_q, done_q, res_fail_q;
  logic             over;

  always_comb begin
    over        = int'(open_cnt) > MAX_ERR;
    remain_zero = (remain_q == '0);
    page_failed = failed_q;
    done        = done_q;
    fixed_cnt   = res_cnt_q;
    fail        = res_fail_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q   <= '0;
      applied_q  <= '0;
      failed_q   <= 1'b0;
      done_q     <= 1'b0;
      res_cnt_q  <= '0;
      res_fail_q <= 1'b0;
    end else begin
      done_q <= close_pg;
      if (open_pg) begin
        remain_q  <= over ? '0 : open_cnt;
        applied_q <= '0;
        failed_q  <= over;
      end else if (take) begin
        remain_q <= remain_q - CNT_W'(1);
        if (!failed_q) begin
          if (take_bad) failed_q  <= 1'b1;
          else          applied_q <= applied_q + CNT_W'(1);
        end
      end
      if (close_pg) begin
        res_cnt_q  <= failed_q ? '0 : applied_q;
        res_fail_q <= failed_q;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(fixed_cnt) <= MAX_ERR)); // R10
  AST_FAIL_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (fixed_cnt == '0)); // R10
  AST_TAKE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !remain_zero); // R11

endmodule

// File: rtl/sym2byte_corrector.sv
module sym2byte_corrector
  import corr_pkg::*;
#(
  parameter  int DATA_BYTES  = 2048,
  parameter  int SPARE_BYTES = 64,
  parameter  int LAST_POS    = 1374,
  parameter  int MAX_ERR     = 4,
  localparam int CNT_W       = $clog2(MAX_ERR + 1),
  localparam int ADDR_W      = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  err_cnt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYM_W-1:0]  in_pos,
  input  logic [SYM_W-1:0]  in_pat,
  output logic              mem_rd,
  output logic              mem_we,
  output logic              mem_spare,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  fixed_cnt,
  output logic              fail
);

  byte_op_t map_op0, map_op1;
  logic     map_bad;
  logic     remain_zero, page_failed;
  logic     open_pg, take, close_pg;

  corr_sym_map #(
    .DATA_BYTES (DATA_BYTES),
    .LAST_POS   (LAST_POS)
  ) map_i (
    .pos (in_pos),
    .pat (in_pat),
    .op0 (map_op0),
    .op1 (map_op1),
    .bad (map_bad)
  );

  corr_rmw_seq #(
    .ADDR_W      (ADDR_W),
    .SPARE_BYTES (SPARE_BYTES)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .map_op0     (map_op0),
    .map_op1     (map_op1),
    .map_bad     (map_bad),
    .remain_zero (remain_zero),
    .page_failed (page_failed),
    .open_pg     (open_pg),
    .take        (take),
    .close_pg    (close_pg),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .mem_spare   (mem_spare),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata)
  );

  corr_tally #(
    .MAX_ERR (MAX_ERR),
    .CNT_W   (CNT_W)
  ) tally_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_pg     (open_pg),
    .open_cnt    (err_cnt),
    .take        (take),
    .take_bad    (map_bad),
    .close_pg    (close_pg),
    .remain_zero (remain_zero),
    .page_failed (page_failed),
    .done        (done),
    .fixed_cnt   (fixed_cnt),
    .fail        (fail)
  );

endmodule

// File: tb/sym2byte_corrector_tb.sv
module sym2byte_corrector_tb_top;

  localparam int DB = 2048;
  localparam int SB = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  err_cnt;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_pos, in_pat;
  logic        mem_rd, mem_we, mem_spare;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, fail;
  logic [2:0]  fixed_cnt;

  logic [7:0] dmem [DB];
  logic [7:0] smem [SB];
  logic [7:0] edm  [DB];
  logic [7:0] esm  [SB];

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sym2byte_corrector dut_i (
    .clk, .rst_n, .start, .err_cnt, .in_valid, .in_ready, .in_pos, .in_pat,
    .mem_rd, .mem_we, .mem_spare, .mem_addr, .mem_wdata, .mem_rdata,
    .done, .fixed_cnt, .fail
  );

  function automatic logic [7:0] fill(input int i, input bit sp);
    return 8'((i * 37) + (sp ? 91 : 11));
  endfunction

  // Byte RAM model: one-cycle read latency, preloaded during reset.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DB; i++) dmem[i] <= fill(i, 1'b0);
      for (int i = 0; i < SB; i++) smem[i] <= fill(i, 1'b1);
    end else begin
      if (mem_rd) mem_rdata <= mem_spare ? smem[mem_addr[5:0]] : dmem[mem_addr];
      if (mem_we) begin
        if (mem_spare) smem[mem_addr[5:0]] <= mem_wdata;
        else           dmem[mem_addr]      <= mem_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bit-serial model: symbol p>0 starts at stream bit 12p-4, MSB first.
  task automatic model_apply(input int p, input int pat, output bit ok);
    ok = 1'b1;
    if (p > 1374) ok = 1'b0;
    else if (p == 0) begin
      if (pat > 255) ok = 1'b0;
      else edm[0] ^= 8'(pat);
    end else begin
      for (int k = 0; k < 12; k++) begin
        if (pat[11-k]) begin
          automatic int g  = 12 * p - 4 + k;
          automatic int by = g / 8;
          automatic int bt = 7 - (g % 8);
          if (by < DB) edm[by][bt] = ~edm[by][bt];
          else         esm[by-DB][bt] = ~esm[by-DB][bt];
        end
      end
    end
  endtask

  task automatic run_page(input string tag, input int n, input int ps[4], input int pt[4]);
    bit exp_fail;
    int applied, lat, last_acc, t_done, mism, first_bad;
    bit rdy_bad;
    exp_fail = (n > 4);
    applied  = 0;
    lat      = 2;
    rdy_bad  = 1'b0;
    @(negedge clk);
    start    = 1'b1;
    err_cnt  = 3'(n);
    last_acc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (n >= 1 && n <= 4) begin
      for (int i = 0; i < n; i++) begin
        automatic bit was_failed = exp_fail;
        automatic bit ok = 1'b0;
        repeat ($urandom_range(2, 0)) @(negedge clk);
        in_valid = 1'b1;
        in_pos   = 12'(ps[i]);
        in_pat   = 12'(pt[i]);
        while (!in_ready) @(negedge clk);
        last_acc = cyc;
        if (!was_failed) begin
          model_apply(ps[i], pt[i], ok);
          if (!ok) begin
            exp_fail = 1'b1;
            lat = 2;
          end else begin
            applied++;
            lat = (ps[i] == 0) ? 4 : 6;
          end
        end else lat = 2;
        @(negedge clk);
        in_valid = 1'b0;
        if (!was_failed && ok) chk(in_ready == 1'b0, "R11", "in_ready after accept", int'(in_ready), 0);
      end
    end
    t_done = -1;
    for (int w = 0; w < 40; w++) begin
      if (done) begin
        t_done = cyc;
        break;
      end
      if (n > 4 && in_ready) rdy_bad = 1'b1;
      @(negedge clk);
    end
    chk(t_done == last_acc + lat, "R11", {tag, " done cycle"}, t_done, last_acc + lat);
    chk(int'(fixed_cnt) == (exp_fail ? 0 : applied), "R10", {tag, " fixed_cnt"}, int'(fixed_cnt), exp_fail ? 0 : applied);
    chk(fail == exp_fail, tag, "fail flag", int'(fail), int'(exp_fail));
    if (n > 4) chk(!rdy_bad, "R8", "in_ready raised for oversize count", int'(rdy_bad), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", int'(done), 0);
    mism = 0;
    first_bad = -1;
    for (int i = 0; i < DB; i++) if (dmem[i] !== edm[i]) begin mism++; if (first_bad < 0) first_bad = i; end
    for (int i = 0; i < SB; i++) if (smem[i] !== esm[i]) begin mism++; if (first_bad < 0) first_bad = DB + i; end
    chk(mism == 0, tag, "page bytes (mismatch count, first index)", mism, 0);
    if (mism != 0) $display("  first differing byte index %0d", first_bad);
  endtask

  task automatic main_seq();
    rst_n    = 1'b0;
    start    = 1'b0;
    err_cnt  = '0;
    in_valid = 1'b0;
    in_pos   = '0;
    in_pat   = '0;
    for (int i = 0; i < DB; i++) edm[i] = fill(i, 1'b0);
    for (int i = 0; i < SB; i++) esm[i] = fill(i, 1'b1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && fail == 0 && fixed_cnt == 0, "R1", "result outputs after reset", int'({done, fail, fixed_cnt}), 0);
    chk(in_ready == 0 && mem_rd == 0 && mem_we == 0, "R1", "handshake and RAM strobes after reset", int'({in_ready, mem_rd, mem_we}), 0);

    run_page("R8", 0, '{0, 0, 0, 0}, '{0, 0, 0, 0});
    run_page("R8", 6, '{0, 0, 0, 0}, '{0, 0, 0, 0});
    run_page("R2", 2, '{1, 777, 0, 0}, '{'hABC, 'h5A3, 0, 0});
    run_page("R3", 2, '{2, 1000, 0, 0}, '{'h5E7, 'hC18, 0, 0});
    run_page("R4", 1, '{0, 0, 0, 0}, '{'h5A, 0, 0, 0});
    run_page("R4", 1, '{0, 0, 0, 0}, '{'h1FF, 0, 0, 0});
    run_page("R5", 1, '{1365, 0, 0, 0}, '{'hF3C, 0, 0, 0});
    run_page("R6", 3, '{1366, 1374, 1367, 0}, '{'h123, 'hFFF, 'h9A5, 0});
    run_page("R7", 3, '{10, 1375, 20, 0}, '{'h777, 'h111, 'h222, 0});
    run_page("R7", 2, '{4095, 30, 0, 0}, '{'h0F0, 'h333, 0, 0});
    run_page("R9", 4, '{3, 4, 3, 3}, '{'hA5C, 'h3C3, 'h0FF, 'hF00});

    for (int pg = 0; pg < 60; pg++) begin
      automatic int n = $urandom_range(4, 1);
      automatic int ps[4];
      automatic int pt[4];
      for (int i = 0; i < 4; i++) begin
        automatic int sel = $urandom_range(15, 0);
        if (sel == 0)      ps[i] = $urandom_range(4095, 1375);
        else if (sel == 1) ps[i] = 0;
        else if (sel < 5 && i > 0) ps[i] = (ps[i-1] < 1374) ? ps[i-1] + $urandom_range(1, 0) : ps[i-1];
        else               ps[i] = $urandom_range(1374, 1);
        pt[i] = $urandom_range(4095, 0);
      end
      run_page("R12", n, ps, pt);
    end
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    void'($urandom(32'd20240611));
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule